// File: doc/BRIEF.md
# Word merge and byte-align shifter

This block combines two data words into one by shifting. A request carries a source word, a destination word, a shift amount, a byte position and a two-bit operation code. One cycle later the block returns a registered result word together with a one-cycle valid pulse. It is meant to sit in the execute stage of a packed-data datapath, where merging bit fields, aligning unaligned byte streams and crossing halfwords are common.

Four operations are available. Append shifts the destination left and fills the vacated low bits from the bottom of the source. Prepend shifts the destination right and fills the vacated high bits from the bottom of the source. Byte-align joins the destination and source at a byte boundary. Cross-pack builds a word from the low half of the source and the high half of the destination. The append and prepend paths can be built either as a staged logarithmic shifter or from the shift operator, selected by a parameter.

Top module: `wmerge_shifter`

## Requirements
- R1: While reset is asserted and after its release, `res_word` is 0 and `res_valid` is 0 until the first request is accepted.
- R2: A request with `req_valid` high produces `res_valid` high on the next rising edge, carrying that request's result in `res_word`. Without a request, `res_valid` is low on the next edge and `res_word` keeps its value.
- R3: Operation code 2'b00 (append) with `shamt` = n, 1 to 31, gives `(dst_word << n) | (src_word & ((1 << n) - 1))`.
- R4: Append with `shamt` = 0 gives `dst_word` unchanged.
- R5: Operation code 2'b01 (prepend) with `shamt` = n, 1 to 31, gives `(dst_word >> n) | (src_word << (32 - n))`, so the low n bits of the source fill the top n bits of the result.
- R6: Prepend with `shamt` = 0 gives `dst_word` unchanged.
- R7: Operation code 2'b10 (byte-align) with `byte_pos` = 1 gives `(dst_word << 8) | (src_word >> 24)`, and with `byte_pos` = 3 gives `(dst_word << 24) | (src_word >> 8)`.
- R8: Byte-align with `byte_pos` = 0 or 2 gives `dst_word` unchanged.
- R9: Operation code 2'b11 (cross-pack) gives `src_word[15:0]` in bits 31:16 and `dst_word[31:16]` in bits 15:0.
- R10: `byte_pos` has no effect on append, prepend or cross-pack. `shamt` has no effect on byte-align or cross-pack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | Operation code: 00 append, 01 prepend, 10 byte-align, 11 cross-pack |
| src_word | input | 32 | Source operand |
| dst_word | input | 32 | Destination operand |
| shamt | input | 5 | Shift amount for append and prepend |
| byte_pos | input | 2 | Byte position for byte-align |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_word | output | 32 | Registered result word |

## Verification
The assertions assume that every input field is a known value in any cycle where `req_valid` is high, and that requests may arrive in consecutive cycles with no gap. They also rely on `req_op` using only the four listed codes, which is true of any 2-bit value. The stimulus drives all fields from a seeded random source on the falling clock edge. It keeps them at defined values at all times, including idle cycles, where it deliberately changes the operands to show that they do not disturb the held result.

// File: rtl/wms_pkg.sv
package wms_pkg;

   typedef enum logic [1:0] {
      WMS_APPEND  = 2'b00,
      WMS_PREPEND = 2'b01,
      WMS_BALIGN  = 2'b10,
      WMS_XPACK   = 2'b11
   } wms_op_e;

   localparam int WMS_LANES = 4;

endpackage

// File: rtl/wms_barrel.sv
module wms_barrel #(
   parameter int W          = 32,
   parameter int SA_W       = 5,
   parameter bit SHIFT_LEFT = 1'b1,
   parameter bit STAGED     = 1'b1
) (
   input  logic [W-1:0]    data_i,
   input  logic [SA_W-1:0] amt_i,
   output logic [W-1:0]    data_o
);

   generate
      if (STAGED) begin : g_staged
         logic [W-1:0] stg [0:SA_W];
         assign stg[0] = data_i;
         for (genvar s = 0; s < SA_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            if (SHIFT_LEFT) begin : g_l
               assign stg[s+1] = amt_i[s] ? (stg[s] << STEP) : stg[s];
            end else begin : g_r
               assign stg[s+1] = amt_i[s] ? (stg[s] >> STEP) : stg[s];
            end
         end
         assign data_o = stg[SA_W];
      end else begin : g_flat
         if (SHIFT_LEFT) begin : g_l
            assign data_o = data_i << amt_i;
         end else begin : g_r
            assign data_o = data_i >> amt_i;
         end
      end
   endgenerate

endmodule

// File: rtl/wms_append.sv
module wms_append #(
   parameter int W      = 32,
   parameter int SA_W   = 5,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]    src_i,
   input  logic [W-1:0]    dst_i,
   input  logic [SA_W-1:0] len_i,
   output logic [W-1:0]    res_o
);

   logic [W-1:0] dst_shl;
   logic [W-1:0] ones_shl;
   logic [W-1:0] keep_mask;

   wms_barrel #(.W(W), .SA_W(SA_W), .SHIFT_LEFT(1'b1), .STAGED(STAGED)) u_dst_shl (
      .data_i (dst_i),
      .amt_i  (len_i),
      .data_o (dst_shl)
   );

   wms_barrel #(.W(W), .SA_W(SA_W), .SHIFT_LEFT(1'b1), .STAGED(STAGED)) u_mask_shl (
      .data_i ({W{1'b1}}),
      .amt_i  (len_i),
      .data_o (ones_shl)
   );

   assign keep_mask = ~ones_shl;

   always_comb begin
      if (len_i == '0) res_o = dst_i;
      else             res_o = dst_shl | (src_i & keep_mask);
   end

endmodule

// File: rtl/wms_prepend.sv
module wms_prepend #(
   parameter int W      = 32,
   parameter int SA_W   = 5,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]    src_i,
   input  logic [W-1:0]    dst_i,
   input  logic [SA_W-1:0] amt_i,
   output logic [W-1:0]    res_o
);

   logic [SA_W-1:0] comp_amt;
   logic [W-1:0]    dst_shr;
   logic [W-1:0]    src_top;

   // W - amt, taken modulo W; only used when amt is non-zero
   assign comp_amt = ~amt_i + 1'b1;

   wms_barrel #(.W(W), .SA_W(SA_W), .SHIFT_LEFT(1'b0), .STAGED(STAGED)) u_dst_shr (
      .data_i (dst_i),
      .amt_i  (amt_i),
      .data_o (dst_shr)
   );

   wms_barrel #(.W(W), .SA_W(SA_W), .SHIFT_LEFT(1'b1), .STAGED(STAGED)) u_src_shl (
      .data_i (src_i),
      .amt_i  (comp_amt),
      .data_o (src_top)
   );

   always_comb begin
      if (amt_i == '0) res_o = dst_i;
      else             res_o = dst_shr | src_top;
   end

endmodule

// File: rtl/wms_balign.sv
module wms_balign #(
   parameter int W = 32
) (
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] dst_i,
   input  logic [1:0]   pos_i,
   output logic [W-1:0] res_o
);

   localparam int LANE_W = W / wms_pkg::WMS_LANES;

   logic [W-1:0] join_one;
   logic [W-1:0] join_three;

   assign join_one   = (dst_i << LANE_W)       | (src_i >> (3 * LANE_W));
   assign join_three = (dst_i << (3 * LANE_W)) | (src_i >> LANE_W);

   always_comb begin
      unique case (pos_i)
         2'd1:    res_o = join_one;
         2'd3:    res_o = join_three;
         default: res_o = dst_i;
      endcase
   end

endmodule

// File: rtl/wmerge_shifter.sv
module wmerge_shifter #(
   parameter int WORD_W       = 32,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int SA_W        = $clog2(WORD_W),
   localparam int HALF_W      = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [WORD_W-1:0] src_word,
   input  logic [WORD_W-1:0] dst_word,
   input  logic [SA_W-1:0]   shamt,
   input  logic [1:0]        byte_pos,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_word
);

   import wms_pkg::*;

   generate
      if (WORD_W < 8 || (WORD_W % WMS_LANES) != 0) begin : g_bad_lane
         $error("wmerge_shifter: WORD_W must be at least 8 and a multiple of 4");
      end
      if ((1 << SA_W) != WORD_W) begin : g_bad_pow2
         $error("wmerge_shifter: WORD_W must be a power of two");
      end
   endgenerate

   logic [WORD_W-1:0] app_res;
   logic [WORD_W-1:0] pre_res;
   logic [WORD_W-1:0] bal_res;
   logic [WORD_W-1:0] pack_res;
   logic [WORD_W-1:0] next_word;
   wms_op_e           op;

   assign op = wms_op_e'(req_op);

   wms_append #(.W(WORD_W), .SA_W(SA_W), .STAGED(STAGED_SHIFT)) u_append (
      .src_i (src_word),
      .dst_i (dst_word),
      .len_i (shamt),
      .res_o (app_res)
   );

   wms_prepend #(.W(WORD_W), .SA_W(SA_W), .STAGED(STAGED_SHIFT)) u_prepend (
      .src_i (src_word),
      .dst_i (dst_word),
      .amt_i (shamt),
      .res_o (pre_res)
   );

   wms_balign #(.W(WORD_W)) u_balign (
      .src_i (src_word),
      .dst_i (dst_word),
      .pos_i (byte_pos),
      .res_o (bal_res)
   );

   assign pack_res = {src_word[HALF_W-1:0], dst_word[WORD_W-1:HALF_W]};

   always_comb begin
      unique case (op)
         WMS_APPEND:  next_word = app_res;
         WMS_PREPEND: next_word = pre_res;
         WMS_BALIGN:  next_word = bal_res;
         default:     next_word = pack_res;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_word  <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) res_word <= next_word;
      end
   end

endmodule

// File: rtl/wms_checker.sv
module wms_checker #(
   parameter int WORD_W  = 32,
   localparam int SA_W   = $clog2(WORD_W),
   localparam int HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [WORD_W-1:0] src_word,
   input logic [WORD_W-1:0] dst_word,
   input logic [SA_W-1:0]   shamt,
   input logic [1:0]        byte_pos,
   input logic              res_valid,
   input logic [WORD_W-1:0] res_word
);

   import wms_pkg::*;

   // R2: a request yields a valid pulse on the next edge
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R2: no request, no pulse, and the result word holds
   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && $stable(res_word)));

   // R4: append of zero length passes the destination through
   assert_append_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_APPEND && shamt == '0) |=> (res_word == $past(dst_word)));

   // R6: prepend of zero amount passes the destination through
   assert_prepend_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_PREPEND && shamt == '0) |=> (res_word == $past(dst_word)));

   // R8: byte-align at an even position passes the destination through
   assert_balign_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_BALIGN && byte_pos[0] == 1'b0) |=> (res_word == $past(dst_word)));

   // R9: cross-pack places the crossed halves
   assert_xpack_halves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_XPACK) |=>
         (res_word == {$past(src_word[HALF_W-1:0]), $past(dst_word[WORD_W-1:HALF_W])}));

   // R3: append keeps the low source bits below the shifted destination
   assert_append_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_APPEND && shamt == SA_W'(1)) |=>
         (res_word == {$past(dst_word[WORD_W-2:0]), $past(src_word[0])}));

   // R5: prepend of one puts the source bit on top
   assert_prepend_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == WMS_PREPEND && shamt == SA_W'(1)) |=>
         (res_word == {$past(src_word[0]), $past(dst_word[WORD_W-1:1])}));

endmodule

bind wmerge_shifter wms_checker #(.WORD_W(WORD_W)) u_wms_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .src_word  (src_word),
   .dst_word  (dst_word),
   .shamt     (shamt),
   .byte_pos  (byte_pos),
   .res_valid (res_valid),
   .res_word  (res_word)
);

// File: tb/wmerge_shifter_bench.sv
`timescale 1ns/1ps
module wmerge_shifter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] src_word = '0;
   logic [31:0] dst_word = '0;
   logic [4:0]  shamt = '0;
   logic [1:0]  byte_pos = '0;
   logic        res_valid;
   logic [31:0] res_word;

   int checks = 0;
   int errors = 0;
   logic [31:0] last_word = '0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wmerge_shifter u_wmerge_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .src_word  (src_word),
      .dst_word  (dst_word),
      .shamt     (shamt),
      .byte_pos  (byte_pos),
      .res_valid (res_valid),
      .res_word  (res_word)
   );

   function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] s,
                                         input logic [31:0] d, input logic [4:0] sa,
                                         input logic [1:0] pos);
      int n;
      n = int'(sa);
      case (op)
         2'b00: model = (n == 0) ? d : ((d << n) | (s & ((32'h1 << n) - 32'h1)));
         2'b01: model = (n == 0) ? d : ((d >> n) | (s << (32 - n)));
         2'b10: model = pos[0] ? ((d << (8 * int'(pos))) | (s >> (8 * (4 - int'(pos))))) : d;
         default: model = {s[15:0], d[31:16]};
      endcase
   endfunction

   function automatic string op_tag(input logic [1:0] op, input logic [4:0] sa,
                                    input logic [1:0] pos);
      case (op)
         2'b00: op_tag = (sa == 0) ? "R4" : "R3";
         2'b01: op_tag = (sa == 0) ? "R6" : "R5";
         2'b10: op_tag = pos[0] ? "R7" : "R8";
         default: op_tag = "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; result checked at the next falling edge
   task automatic request(input logic [1:0] op, input logic [31:0] s, input logic [31:0] d,
                          input logic [4:0] sa, input logic [1:0] pos, input string extra);
      logic [31:0] exp;
      exp = model(op, s, d, sa, pos);
      req_valid = 1'b1; req_op = op; src_word = s; dst_word = d; shamt = sa; byte_pos = pos;
      @(negedge clk);
      check(res_valid == 1'b1, "R2 valid", {31'd0, res_valid}, 32'd1);
      check(res_word == exp, {op_tag(op, sa, pos), extra}, res_word, exp);
      last_word = exp;
   endtask

   task automatic idle(input logic [31:0] s, input logic [31:0] d);
      req_valid = 1'b0; src_word = s; dst_word = d; shamt = 5'd7; byte_pos = 2'd1;
      @(negedge clk);
      check(res_valid == 1'b0, "R2 idle valid", {31'd0, res_valid}, 32'd0);
      check(res_word == last_word, "R2 idle hold", res_word, last_word);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(res_word == 32'd0, "R1 reset word", res_word, 32'd0);
      check(res_valid == 1'b0, "R1 reset valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_word == 32'd0, "R1 after release", res_word, 32'd0);

      // directed corners
      request(2'b00, 32'hFFFF_FFFF, 32'h1234_5678, 5'd0,  2'd0, " append len 0");
      request(2'b00, 32'hABCD_EF0F, 32'h1234_5678, 5'd4,  2'd0, " append len 4");
      request(2'b00, 32'h7FFF_FFFF, 32'h8000_0001, 5'd31, 2'd0, " append len 31");
      request(2'b01, 32'hFFFF_FFFF, 32'h1234_5678, 5'd0,  2'd0, " prepend 0");
      request(2'b01, 32'h0000_0001, 32'h8000_0000, 5'd1,  2'd0, " prepend 1");
      request(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 5'd31, 2'd0, " prepend 31");
      request(2'b10, 32'hAABB_CCDD, 32'h1122_3344, 5'd0,  2'd0, " balign pos 0");
      request(2'b10, 32'hAABB_CCDD, 32'h1122_3344, 5'd0,  2'd1, " balign pos 1");
      request(2'b10, 32'hAABB_CCDD, 32'h1122_3344, 5'd0,  2'd2, " balign pos 2");
      request(2'b10, 32'hAABB_CCDD, 32'h1122_3344, 5'd0,  2'd3, " balign pos 3");
      request(2'b11, 32'hAABB_CCDD, 32'h1122_3344, 5'd0,  2'd0, " xpack");
      // R10: unused fields ignored
      request(2'b10, 32'hAABB_CCDD, 32'h1122_3344, 5'd19, 2'd3, " R10 shamt ignored in balign");
      request(2'b11, 32'hAABB_CCDD, 32'h1122_3344, 5'd9,  2'd2, " R10 fields ignored in xpack");
      request(2'b00, 32'hABCD_EF0F, 32'h1234_5678, 5'd4,  2'd3, " R10 pos ignored in append");
      request(2'b01, 32'h0000_00F3, 32'h1234_5678, 5'd8,  2'd1, " R10 pos ignored in prepend");
      idle(32'hDEAD_BEEF, 32'hCAFE_F00D);
      idle(32'h0, 32'hFFFF_FFFF);

      // constrained random, mostly back to back
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 3) == 0) begin
            idle($urandom, $urandom);
         end else begin
            logic [4:0] sa;
            case ($urandom_range(0, 5))
               0:       sa = 5'd0;
               1:       sa = 5'd31;
               default: sa = 5'($urandom);
            endcase
            request(2'($urandom), $urandom, $urandom, sa, 2'($urandom), " random");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule